// File: doc/BRIEF.md
# Dual-Length Cyclic Prefix Inserter

This block takes time-domain OFDM symbols of 512 complex samples from an inverse transform and emits every symbol with a guard interval in front of it. The guard interval is a copy of the symbol's own final samples. Its length follows the symbol's position in the slot. The one position selected by a parameter (index 0) gets a 40-sample prefix. The other six positions get a 36-sample prefix. An output symbol is therefore 552 or 548 samples long.

Two RAM banks take turns. One bank collects the incoming symbol while the other bank replays the symbol that arrived before it: the tail first, then the whole symbol from its first sample. A frame controller supplies the slot position on `sym_idx` together with the first sample of each symbol. The block starts the replay a fixed number of cycles later, so a receiver can time its own start strobe by adding this delay to the delay of the upstream transform.

The upstream side follows two rules:
- The 512 samples of a symbol arrive on consecutive cycles.
- A new symbol starts no sooner than one output-symbol length after the start of the previous one.

When the upstream side sends at exactly that spacing, the output stream has no gaps.

Top module: `cp_inserter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` and `out_cp` are 0 and `out_i`/`out_q` are 0. Reset discards a symbol that is only partly received, and nothing from it is ever emitted.
- R2: `sym_idx` is sampled with the first sample of each symbol. If the value is 0, the prefix is 40 samples and the output symbol is 552 samples. Any other value (1 to 7) gives a 36-sample prefix and a 548-sample output symbol.
- R3: With a prefix length N, the output of a symbol is input samples 512−N through 511, followed by input samples 0 through 511. Sample n is the n-th sample accepted with `in_valid` high, counting from 0.
- R4: `out_cp` is 1 on exactly the N prefix samples of each output symbol and 0 on its 512 body samples. Every output symbol begins with its prefix.
- R5: Let the first sample of a symbol be accepted on clock edge k. The first prefix sample of that symbol is then present on the outputs right after edge k+514.
- R6: Changes on `sym_idx` during samples 1 to 511 of a symbol do not change that symbol's prefix length.
- R7: If each symbol starts exactly one output-symbol length after the previous one, consecutive output symbols follow each other with no idle cycle.
- R8: Whenever `out_valid` is 0, `out_i` and `out_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase sample |
| in_q | input | 16 | Input quadrature sample |
| sym_idx | input | 3 | Symbol position in the slot, taken at the first sample |
| out_valid | output | 1 | Output sample strobe |
| out_cp | output | 1 | High while the output sample belongs to the prefix |
| out_i | output | 16 | Output in-phase sample |
| out_q | output | 16 | Output quadrature sample |

## Verification
The checker watches the output stream on every cycle:
- Each prefix run ends after 36 or 40 samples, and only into a body.
- Each body run is exactly 512 samples long.
- `out_cp` never appears without `out_valid`.
- A symbol never starts with a body sample.
- Idle outputs are zero.

Other properties need the input to be known, so only the bench scenarios can show them:
- The prefix matches the actual tail of the symbol and follows the right slot position.
- A mid-symbol change of `sym_idx` is ignored.
- The 514-cycle latency holds.
- The output stays gapless under back-to-back input.
- A partly received symbol is dropped by reset.

// File: rtl/cp_inserter.sv
module cp_inserter #(
  parameter int DW        = 16,
  parameter int SYM_LEN   = 512,
  parameter int CP_LONG   = 40,
  parameter int CP_SHORT  = 36,
  parameter int SLOT_SYMS = 7,
  parameter int LONG_SLOT = 0,
  parameter int IW        = $clog2(SLOT_SYMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [IW-1:0] sym_idx,
  output logic          out_valid,
  output logic          out_cp,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  localparam int AW = $clog2(SYM_LEN);
  localparam int CW = $clog2(SYM_LEN + CP_LONG);
  localparam int LW = $clog2(CP_LONG + 1);

  logic [2*DW-1:0] mem [2*SYM_LEN];

  logic            in_v_q;
  logic [2*DW-1:0] in_d_q;
  logic [IW-1:0]   sidx_q;

  logic [AW-1:0] wr_cnt;
  logic          wr_bank;
  logic [LW-1:0] wr_len;

  logic          rd_active;
  logic          rd_bank;
  logic [CW-1:0] rd_cnt;
  logic [LW-1:0] rd_len;

  logic            v1, c1;
  logic [2*DW-1:0] rd_data;

  wire wr_first = in_v_q && (wr_cnt == '0);
  wire wr_last  = in_v_q && (wr_cnt == AW'(SYM_LEN - 1));
  wire [LW-1:0] new_len = (sidx_q == IW'(LONG_SLOT)) ? LW'(CP_LONG) : LW'(CP_SHORT);
  wire rd_in_cp = rd_cnt < CW'(rd_len);
  wire rd_last  = rd_cnt == (CW'(SYM_LEN - 1) + CW'(rd_len));
  wire [AW-1:0] rd_addr = AW'(rd_in_cp ? (rd_cnt + CW'(SYM_LEN) - CW'(rd_len))
                                       : (rd_cnt - CW'(rd_len)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_v_q <= 1'b0;
    end else begin
      in_v_q <= in_valid;
    end
    in_d_q <= {in_i, in_q};
    sidx_q <= sym_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      wr_bank <= 1'b0;
      wr_len  <= '0;
    end else if (in_v_q) begin
      wr_cnt <= wr_last ? '0 : wr_cnt + 1'b1;
      if (wr_first) wr_len <= new_len;
      if (wr_last)  wr_bank <= ~wr_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v_q) mem[{wr_bank, wr_cnt}] <= in_d_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_bank   <= 1'b0;
      rd_cnt    <= '0;
      rd_len    <= '0;
    end else if (wr_last) begin
      rd_active <= 1'b1;
      rd_bank   <= wr_bank;
      rd_cnt    <= '0;
      rd_len    <= wr_first ? new_len : wr_len;
    end else if (rd_active) begin
      rd_cnt <= rd_cnt + 1'b1;
      if (rd_last) rd_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[{rd_bank, rd_addr}];
    if (!rst_n) begin
      v1 <= 1'b0;
      c1 <= 1'b0;
    end else begin
      v1 <= rd_active;
      c1 <= rd_active && rd_in_cp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cp    <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= v1;
      out_cp    <= c1;
      out_i     <= v1 ? rd_data[2*DW-1:DW] : '0;
      out_q     <= v1 ? rd_data[DW-1:0]    : '0;
    end
  end
endmodule

// File: rtl/cp_inserter_chk.sv
module cp_inserter_chk #(
  parameter int DW       = 16,
  parameter int SYM_LEN  = 512,
  parameter int CP_LONG  = 40,
  parameter int CP_SHORT = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_cp,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q
);
  localparam int NW = $clog2(SYM_LEN + CP_LONG) + 1;

  logic [NW-1:0] cp_run, body_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_run   <= '0;
      body_run <= '0;
    end else begin
      cp_run   <= (out_valid && out_cp)  ? cp_run + 1'b1   : '0;
      body_run <= (out_valid && !out_cp) ? body_run + 1'b1 : '0;
    end
  end

  AST_CP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_cp |-> out_valid); // R4

  AST_SYMBOL_OPENS_WITH_CP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_cp); // R4

  AST_PREFIX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_run != '0 && !out_cp) |->
      (out_valid && (cp_run == NW'(CP_LONG) || cp_run == NW'(CP_SHORT)))); // R2

  AST_BODY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (body_run != '0 && !(out_valid && !out_cp)) |-> body_run == NW'(SYM_LEN)); // R3

  AST_BODY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    body_run <= NW'(SYM_LEN)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_i == '0 && out_q == '0)); // R8
endmodule

bind cp_inserter cp_inserter_chk #(
  .DW(DW), .SYM_LEN(SYM_LEN), .CP_LONG(CP_LONG), .CP_SHORT(CP_SHORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_cp(out_cp),
  .out_i(out_i), .out_q(out_q)
);

// File: tb/cp_inserter_tb.sv
module cp_inserter_tb;
  localparam int SYM  = 512;
  localparam int NSYM = 8;
  // fields: [31:29] slot index, [28] change sym_idx mid-symbol, [27:16] idle gap before, [15:0] seed
  localparam logic [31:0] TBL [NSYM] = '{
    {3'd0, 1'b0, 12'd7,  16'h1000},
    {3'd1, 1'b0, 12'd0,  16'h2345},
    {3'd2, 1'b0, 12'd5,  16'h7ff0},
    {3'd3, 1'b1, 12'd0,  16'h8001},
    {3'd6, 1'b0, 12'd0,  16'hfff0},
    {3'd0, 1'b1, 12'd20, 16'h0a0a},
    {3'd7, 1'b0, 12'd0,  16'h5555},
    {3'd0, 1'b0, 12'd0,  16'hc3c3}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic [2:0] sym_idx = '0;
  logic out_valid, out_cp;
  logic [15:0] out_i, out_q;

  int checks = 0, errors = 0, cyc = 0;
  int m = 0, pos = 0, stray = 0, idle_bad = 0;
  bit mon_en = 1'b1;
  int in_t [NSYM], out_t [NSYM], cpcnt [NSYM], total [NSYM], sym_err [NSYM];

  cp_inserter u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i),
    .in_q(in_q), .sym_idx(sym_idx), .out_valid(out_valid), .out_cp(out_cp),
    .out_i(out_i), .out_q(out_q));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int plen(input int s);
    return (TBL[s][31:29] == 3'd0) ? 40 : 36;
  endfunction
  function automatic logic [15:0] ei(input int s, input int k);
    return TBL[s][15:0] + 16'(k);
  endfunction
  function automatic logic [15:0] eq(input int s, input int k);
    return TBL[s][15:0] - 16'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int n, k;
    if (rst_n) begin
      if (!mon_en) begin
        if (out_valid) stray++;
      end else begin
        if (!out_valid && (out_i != 0 || out_q != 0)) idle_bad++;
        if (out_valid && m < NSYM) begin
          n = plen(m);
          k = (pos < n) ? SYM - n + pos : pos - n;
          if (pos == 0) out_t[m] = cyc;
          if (out_cp) cpcnt[m]++;
          total[m]++;
          if (out_cp != (pos < n) || out_i != ei(m, k) || out_q != eq(m, k)) sym_err[m]++;
          pos++;
          if (pos == n + SYM) begin pos = 0; m++; end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSYM; s++) begin
      cpcnt[s] = 0; total[s] = 0; sym_err[s] = 0; in_t[s] = 0; out_t[s] = 0;
    end
    // R1: outputs held idle during reset even with input active
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_cp && out_i == 0 && out_q == 0, "R1", "outputs in reset",
        {out_valid, out_cp}, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_cp && out_i == 0 && out_q == 0, "R1", "outputs after reset",
        {out_valid, out_cp}, 0);

    for (int s = 0; s < NSYM; s++) begin
      in_valid = 1'b0;
      sym_idx = 3'd5;
      repeat (int'(TBL[s][27:16])) @(negedge clk);
      for (int n = 0; n < SYM; n++) begin
        if (n == 0) in_t[s] = cyc + 1;
        in_valid = 1'b1;
        in_i = ei(s, n);
        in_q = eq(s, n);
        if (n == 0 || !TBL[s][28]) sym_idx = TBL[s][31:29];
        else sym_idx = (TBL[s][31:29] == 3'd0) ? 3'd3 : 3'd0;
        @(negedge clk);
      end
      in_valid = 1'b0;
      sym_idx = 3'd0;
      in_i = 16'hdead;
      repeat (plen(s) - SYM + SYM) begin
        if (cyc < 0) break;
        @(negedge clk);
        if (plen(s) == 0) break;
      end
    end
    while (m < NSYM) @(negedge clk);
    repeat (3) @(negedge clk);

    for (int s = 0; s < NSYM; s++) begin
      chk(sym_err[s] == 0, "R3", $sformatf("symbol %0d sample/order mismatches", s), sym_err[s], 0);
      chk(total[s] == plen(s) + SYM, "R2", $sformatf("symbol %0d output length", s), total[s], plen(s) + SYM);
      if (TBL[s][28])
        chk(cpcnt[s] == plen(s), "R6", $sformatf("symbol %0d prefix after sym_idx change", s), cpcnt[s], plen(s));
      else
        chk(cpcnt[s] == plen(s), "R4", $sformatf("symbol %0d cp flag count", s), cpcnt[s], plen(s));
      chk(out_t[s] - in_t[s] == 514, "R5", $sformatf("symbol %0d latency", s), out_t[s] - in_t[s], 514);
      if (s > 0 && TBL[s][27:16] == 0)
        chk(out_t[s] - out_t[s-1] == plen(s-1) + SYM, "R7", $sformatf("symbol %0d back-to-back spacing", s),
            out_t[s] - out_t[s-1], plen(s-1) + SYM);
    end
    chk(idle_bad == 0, "R8", "nonzero data while idle", idle_bad, 0);

    // R1: partial symbol dropped by reset
    mon_en = 1'b0;
    for (int n = 0; n < 300; n++) begin
      in_valid = 1'b1; in_i = 16'(n); in_q = 16'(n); sym_idx = 3'd0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (800) @(negedge clk);
    chk(stray == 0 && !out_valid, "R1", "output after mid-symbol reset", stray, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule